// File: doc/BRIEF.md
# I2C Control and Interrupt Register Block

This block is the host-side register front end of a byte-oriented I2C interface. A host writes a control word, a byte-count word and reads back a status word over a minimal register bus with separate write and read addresses. The serial protocol engine sits outside the block; it reports events (data service request, address not acknowledged, data not acknowledged), byte-done strobes, a busy level and the transfer direction, and it receives an enable level and a one-cycle abort pulse.

Four interrupt sources are kept as sticky status flags. Each has an enable bit and a write-one-to-clear bit in the control word, and the enabled flags are ORed into one interrupt request. A master enable bit gates everything: clearing it wipes the flags and the byte counter and aborts the engine. A software pad mode hands the open-drain SDA and SCL pull-downs to two control bits for bit-banging.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After the asynchronous reset every register reads 0, `irq_o` is 0, `xfer_abort_o` is 0 and both pad pull-downs are released (0).
- R2: The control word (address 0) holds enable at bit 0, interrupt enables at bits 4:1 (bit 1 transfer done, bit 2 service request, bit 3 address NACK, bit 4 data NACK), clear strobes at bits 8:5 (same source order), SDA software bit at 9, SCL software bit at 10 and software pad mode at 31. Clear strobes and all other bits read back as 0.
- R3: Writing 1 to a clear strobe clears the matching status flag; writing 0 leaves it unchanged.
- R4: When a source event and its clear strobe arrive in the same cycle, the flag ends set.
- R5: `irq_o` is 1 exactly when some status flag is set whose interrupt enable is 1; a masked flag still reads back in the status word.
- R6: Writing control bit 0 as 0 clears all flags, the remaining count, the programmed count and the direction bit, raises `xfer_abort_o` for one cycle if the block was enabled, and events and count loads are ignored while it stays 0.
- R7: A write to address 2 loads the byte count (bits 15:0 at the default width) only while enabled and `xfer_busy_i` is 0; address 2 reads the last accepted value and status bits 23:8 show the remaining count, which drops by one per `byte_done_i`.
- R8: The transfer-done flag (status bit 0) sets in the cycle the remaining count goes from 1 to 0; a byte-done strobe at count 0 changes nothing.
- R9: Status bit 4 reads 1 while enabled and the engine reports receive (`dir_rx_i` = 1), else 0 (transmit or disabled).
- R10: With software pad mode 1, `sda_low_o` and `scl_low_o` equal control bits 9 and 10 (1 pulls the pad low, 0 releases it); with mode 0 they follow the engine's pull requests gated by the enable.
- R11: Engine event pulses set status bit 1 (service request), bit 2 (address NACK) and bit 3 (data NACK); status bits 7:5 read 0 and writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 control, 1 status, 2 byte count) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data for `rd_addr_i` |
| ev_svc_i | input | 1 | Engine pulse: data register needs service |
| ev_addr_nack_i | input | 1 | Engine pulse: slave address not acknowledged |
| ev_data_nack_i | input | 1 | Engine pulse: slave refused a data byte |
| byte_done_i | input | 1 | Engine pulse: one byte completed |
| xfer_busy_i | input | 1 | Engine level: transfer in progress |
| dir_rx_i | input | 1 | Engine level: 1 receive, 0 transmit |
| hw_sda_low_i | input | 1 | Engine request to pull SDA low |
| hw_scl_low_i | input | 1 | Engine request to pull SCL low |
| irq_o | output | 1 | Combined interrupt request |
| eng_enable_o | output | 1 | Master enable to the engine |
| xfer_abort_o | output | 1 | One-cycle abort pulse on disable |
| sda_low_o | output | 1 | SDA pull-down (1 = pad driven low) |
| scl_low_o | output | 1 | SCL pull-down (1 = pad driven low) |

## Verification
The flag logic is driven with a lone event, an event with an unrelated zero clear write, an event colliding with its own clear strobe, and flags raised under partial masks; together these separate sticky set, write-one-to-clear, set priority and masking. The counter is stepped down through 1 to 0 and once more at 0, and a load is offered while busy and while disabled, telling apart the completion edge from a plain level compare and the load guards. The pads are driven in both modes with engine requests opposing the software bits, which exposes a swapped polarity or a mode select that leaks.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int NSRC    = 4;
  localparam int DATA_W  = 32;
  // control word bit positions
  localparam int C_EN    = 0;
  localparam int C_IEN   = 1;
  localparam int C_CLR   = 5;
  localparam int C_SDA   = 9;
  localparam int C_SCL   = 10;
  localparam int C_SWM   = 31;
  // status word positions
  localparam int S_DIR   = 4;
  localparam int S_CNT   = 8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_CNT  = 2'd2
  } reg_addr_e;

  function automatic logic f_irq(input logic [NSRC-1:0] flags,
                                 input logic [NSRC-1:0] ien);
    return |(flags & ien);
  endfunction

  function automatic logic [NSRC-1:0] f_flag_next(input logic [NSRC-1:0] cur,
                                                  input logic [NSRC-1:0] set,
                                                  input logic [NSRC-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags
  import i2c_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wipe_i,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] ien_i,
  output logic [NSRC-1:0] flags_o,
  output logic            irq_o
);
  logic [NSRC-1:0] flags_q;
  logic [NSRC-1:0] set_ok;

  assign set_ok = wipe_i ? '0 : set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (wipe_i) flags_q <= '0;
    else             flags_q <= f_flag_next(flags_q, set_ok, clr_i);
  end

  assign flags_o = flags_q;
  assign irq_o   = f_irq(flags_q, ien_i);

  // R4: an accepted event always leaves its flag set
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ok != '0) |=> ((flags_q & $past(set_ok)) == $past(set_ok)));
  // R3: a clear without a colliding event leaves the flag at 0
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_ok) != '0) |=> ((flags_q & $past(clr_i & ~set_ok)) == '0));
  // R6: wipe empties all flags
  p_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_i |=> (flags_q == '0));
endmodule

// File: rtl/i2c_byte_counter.sv
module i2c_byte_counter #(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wipe_i,
  input  logic               load_i,
  input  logic [COUNT_W-1:0] load_val_i,
  input  logic               busy_i,
  input  logic               byte_done_i,
  output logic [COUNT_W-1:0] remaining_o,
  output logic [COUNT_W-1:0] programmed_o,
  output logic               hit_zero_o
);
  logic [COUNT_W-1:0] rem_q, prog_q;
  logic               load_ok, dec_ok;

  assign load_ok    = load_i && !busy_i && !wipe_i;
  assign dec_ok     = byte_done_i && !wipe_i && !load_ok && (rem_q != '0);
  assign hit_zero_o = dec_ok && (rem_q == COUNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      prog_q <= '0;
    end else if (wipe_i) begin
      rem_q  <= '0;
      prog_q <= '0;
    end else if (load_ok) begin
      rem_q  <= load_val_i;
      prog_q <= load_val_i;
    end else if (dec_ok) begin
      rem_q  <= rem_q - COUNT_W'(1);
    end
  end

  assign remaining_o  = rem_q;
  assign programmed_o = prog_q;

  // R7: each accepted byte-done lowers the count by exactly one
  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ok |=> (rem_q == $past(rem_q) - COUNT_W'(1)));
  // R8: a byte-done at zero leaves the count at zero
  p_zero_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_i && rem_q == '0 && !load_i) |=> (rem_q == '0));
  // R7: a load offered while busy does not alter the programmed value
  p_busy_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && busy_i && !wipe_i) |=> $stable(prog_q));
endmodule

// File: rtl/i2c_pad_mux.sv
module i2c_pad_mux (
  input  logic sw_mode_i,
  input  logic enable_i,
  input  logic sda_sw_i,
  input  logic scl_sw_i,
  input  logic hw_sda_i,
  input  logic hw_scl_i,
  output logic sda_low_o,
  output logic scl_low_o
);
  always_comb begin
    if (sw_mode_i) begin
      sda_low_o = sda_sw_i;
      scl_low_o = scl_sw_i;
    end else begin
      sda_low_o = enable_i & hw_sda_i;
      scl_low_o = enable_i & hw_scl_i;
    end
  end
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ev_svc_i,
  input  logic              ev_addr_nack_i,
  input  logic              ev_data_nack_i,
  input  logic              byte_done_i,
  input  logic              xfer_busy_i,
  input  logic              dir_rx_i,
  input  logic              hw_sda_low_i,
  input  logic              hw_scl_low_i,
  output logic              irq_o,
  output logic              eng_enable_o,
  output logic              xfer_abort_o,
  output logic              sda_low_o,
  output logic              scl_low_o
);
  localparam int CNT_HI = S_CNT + COUNT_W - 1;

  logic            en_q, sda_sw_q, scl_sw_q, swm_q, abort_q;
  logic [NSRC-1:0] ien_q;

  // named internal events
  logic            ctrl_wr, cnt_wr, en_next, wipe, disable_evt;
  logic [NSRC-1:0] clr_req, ev_vec, flags;
  logic            hit_zero;
  logic [COUNT_W-1:0] remaining, programmed;

  assign ctrl_wr     = wr_en_i && (wr_addr_i == A_CTRL);
  assign cnt_wr      = wr_en_i && (wr_addr_i == A_CNT);
  assign en_next     = ctrl_wr ? wr_data_i[C_EN] : en_q;
  assign wipe        = !en_next;
  assign disable_evt = en_q && ctrl_wr && !wr_data_i[C_EN];
  assign clr_req     = ctrl_wr ? wr_data_i[C_CLR +: NSRC] : '0;
  assign ev_vec      = {ev_data_nack_i, ev_addr_nack_i, ev_svc_i, hit_zero};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ien_q    <= '0;
      sda_sw_q <= 1'b0;
      scl_sw_q <= 1'b0;
      swm_q    <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      abort_q <= disable_evt;
      if (ctrl_wr) begin
        en_q     <= wr_data_i[C_EN];
        ien_q    <= wr_data_i[C_IEN +: NSRC];
        sda_sw_q <= wr_data_i[C_SDA];
        scl_sw_q <= wr_data_i[C_SCL];
        swm_q    <= wr_data_i[C_SWM];
      end
    end
  end

  i2c_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wipe_i(wipe), .set_i(ev_vec), .clr_i(clr_req),
    .ien_i(ien_q), .flags_o(flags), .irq_o(irq_o)
  );

  i2c_byte_counter #(.COUNT_W(COUNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wipe_i(wipe), .load_i(cnt_wr),
    .load_val_i(wr_data_i[COUNT_W-1:0]), .busy_i(xfer_busy_i),
    .byte_done_i(byte_done_i), .remaining_o(remaining),
    .programmed_o(programmed), .hit_zero_o(hit_zero)
  );

  i2c_pad_mux u_pads (
    .sw_mode_i(swm_q), .enable_i(en_q), .sda_sw_i(sda_sw_q), .scl_sw_i(scl_sw_q),
    .hw_sda_i(hw_sda_low_i), .hw_scl_i(hw_scl_low_i),
    .sda_low_o(sda_low_o), .scl_low_o(scl_low_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[C_EN]           = en_q;
        rd_data_o[C_IEN +: NSRC]  = ien_q;
        rd_data_o[C_SDA]          = sda_sw_q;
        rd_data_o[C_SCL]          = scl_sw_q;
        rd_data_o[C_SWM]          = swm_q;
      end
      A_STAT: begin
        rd_data_o[NSRC-1:0]       = flags;
        rd_data_o[S_DIR]          = en_q & dir_rx_i;
        rd_data_o[CNT_HI:S_CNT]   = remaining;
      end
      A_CNT:   rd_data_o[COUNT_W-1:0] = programmed;
      default: rd_data_o = '0;
    endcase
  end

  assign eng_enable_o = en_q;
  assign xfer_abort_o = abort_q;

  // R6: leaving the enabled state is always accompanied by an abort pulse
  p_abort_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> xfer_abort_o);
  // R6: nothing can raise the interrupt while disabled
  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!irq_o && flags == '0 && remaining == '0));
  // R8: reaching zero on a byte-done raises the done flag
  p_done_on_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_zero && !wipe) |=> flags[0]);
  // R10: in software mode the pads follow the register bits
  p_pad_sw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    swm_q |-> (sda_low_o == sda_sw_q && scl_low_o == scl_sw_q));
  // R5: a request without any enabled flag is impossible
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ien_q) == '0) |-> !irq_o);
endmodule

// File: tb/sim_i2c_ctl_regs.sv
`timescale 1ns/1ps
module sim_i2c_ctl_regs;
  localparam int SEL_RD = 0, SEL_IRQ = 1, SEL_PAD = 2, SEL_ABT = 3;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic ev_svc = 0, ev_an = 0, ev_dn = 0, bdone = 0, busy = 0, dir_rx = 0;
  logic hw_sda = 0, hw_scl = 0;
  logic [31:0] rd_data;
  logic irq, eng_en, abort, sda_low, scl_low;

  int n_cmp = 0, n_bad = 0;
  item_t q[$];
  bit done = 0;

  always #5 clk = ~clk;

  i2c_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ev_svc_i(ev_svc), .ev_addr_nack_i(ev_an), .ev_data_nack_i(ev_dn),
    .byte_done_i(bdone), .xfer_busy_i(busy), .dir_rx_i(dir_rx),
    .hw_sda_low_i(hw_sda), .hw_scl_low_i(hw_scl), .irq_o(irq),
    .eng_enable_o(eng_en), .xfer_abort_o(abort), .sda_low_o(sda_low),
    .scl_low_o(scl_low)
  );

  // monitor: pops expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sel)
          SEL_RD:  act = rd_data;
          SEL_IRQ: act = {31'b0, irq};
          SEL_PAD: act = {30'b0, scl_low, sda_low};
          default: act = {31'b0, abort};
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  // driver tasks: each runs from one falling edge to the next
  task automatic expect_v(input int sel, input logic [1:0] a,
                          input logic [31:0] e, input string tag);
    item_t it;
    rd_addr = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1;
    @(negedge clk);
    s = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    expect_v(SEL_RD, 2'd0, 32'h0, "R1 ctrl");
    expect_v(SEL_RD, 2'd1, 32'h0, "R1 status");
    expect_v(SEL_IRQ, 2'd0, 32'h0, "R1 irq");
    expect_v(SEL_PAD, 2'd0, 32'h0, "R1 pads");
    expect_v(SEL_ABT, 2'd0, 32'h0, "R1 abort");
    // R2: reserved bits dropped, enables kept
    wr(2'd0, 32'h7FFF_F81F);
    expect_v(SEL_RD, 2'd0, 32'h0000_001F, "R2 ctrl readback");
    // R7: load count 3
    wr(2'd2, 32'h0000_0003);
    expect_v(SEL_RD, 2'd2, 32'h3, "R7 programmed");
    expect_v(SEL_RD, 2'd1, 32'h300, "R7 remaining");
    // R9: receive direction
    dir_rx = 1;
    expect_v(SEL_RD, 2'd1, 32'h310, "R9 dir rx");
    // R7/R8: count down to zero
    pulse(bdone);
    pulse(bdone);
    expect_v(SEL_RD, 2'd1, 32'h110, "R7 count 1");
    expect_v(SEL_IRQ, 2'd0, 32'h0, "R8 no done early");
    pulse(bdone);
    expect_v(SEL_RD, 2'd1, 32'h011, "R8 done flag");
    expect_v(SEL_IRQ, 2'd0, 32'h1, "R5 irq done");
    pulse(bdone);
    expect_v(SEL_RD, 2'd1, 32'h011, "R8 strobe at zero");
    // R3: write-one-to-clear done; clear strobe reads 0
    wr(2'd0, 32'h0000_003F);
    expect_v(SEL_RD, 2'd1, 32'h010, "R3 clear done");
    expect_v(SEL_IRQ, 2'd0, 32'h0, "R3 irq dropped");
    expect_v(SEL_RD, 2'd0, 32'h1F, "R2 clear bits read 0");
    // R11 + R3: address nack, then zero clear write
    pulse(ev_an);
    expect_v(SEL_RD, 2'd1, 32'h014, "R11 addr nack");
    wr(2'd0, 32'h0000_001F);
    expect_v(SEL_RD, 2'd1, 32'h014, "R3 zero write no effect");
    // R11: writes to status ignored
    wr(2'd1, 32'hFFFF_FFFF);
    expect_v(SEL_RD, 2'd1, 32'h014, "R11 status write ignored");
    // R5: masking
    wr(2'd0, 32'h0000_0003);
    expect_v(SEL_IRQ, 2'd0, 32'h0, "R5 masked addr nack");
    pulse(ev_svc);
    pulse(ev_dn);
    expect_v(SEL_RD, 2'd1, 32'h01E, "R11 svc and data nack");
    expect_v(SEL_IRQ, 2'd0, 32'h0, "R5 still masked");
    wr(2'd0, 32'h0000_0013);
    expect_v(SEL_IRQ, 2'd0, 32'h1, "R5 data nack enabled");
    // R4: event and its clear in the same cycle
    wr_en = 1; wr_addr = 2'd0; wr_data = 32'h0000_0053; ev_svc = 1;
    @(negedge clk);
    wr_en = 0; wr_data = 0; ev_svc = 0;
    expect_v(SEL_RD, 2'd1, 32'h01E, "R4 set beats clear");
    wr(2'd0, 32'h0000_01F3);
    expect_v(SEL_RD, 2'd1, 32'h010, "R3 clear all");
    expect_v(SEL_IRQ, 2'd0, 32'h0, "R3 irq after clear all");
    // R7: load refused while busy, accepted when idle
    busy = 1;
    wr(2'd2, 32'h0000_0005);
    expect_v(SEL_RD, 2'd2, 32'h3, "R7 busy load ignored");
    expect_v(SEL_RD, 2'd1, 32'h010, "R7 busy remaining");
    busy = 0;
    wr(2'd2, 32'h0000_0002);
    expect_v(SEL_RD, 2'd1, 32'h210, "R7 idle load");
    // R6: disable wipes and aborts
    wr(2'd0, 32'h0000_0012);
    expect_v(SEL_ABT, 2'd0, 32'h1, "R6 abort pulse");
    expect_v(SEL_ABT, 2'd0, 32'h0, "R6 abort one cycle");
    expect_v(SEL_RD, 2'd1, 32'h0, "R6 status wiped");
    expect_v(SEL_RD, 2'd2, 32'h0, "R6 count wiped");
    pulse(ev_svc);
    wr(2'd2, 32'h0000_0007);
    expect_v(SEL_RD, 2'd1, 32'h0, "R6 events and loads ignored");
    expect_v(SEL_IRQ, 2'd0, 32'h0, "R6 irq off");
    // R10: pads
    hw_sda = 1;
    expect_v(SEL_PAD, 2'd0, 32'h0, "R10 hw gated by enable");
    wr(2'd0, 32'h0000_0001);
    expect_v(SEL_PAD, 2'd0, 32'h1, "R10 hw sda");
    hw_scl = 1;
    wr(2'd0, 32'h8000_0201);
    expect_v(SEL_PAD, 2'd0, 32'h1, "R10 sw sda low scl free");
    hw_sda = 0;
    wr(2'd0, 32'h8000_0401);
    expect_v(SEL_PAD, 2'd0, 32'h2, "R10 sw scl low sda free");
    expect_v(SEL_RD, 2'd0, 32'h8000_0401, "R2 sw bits readback");
    done = 1;
    summary();
  end
endmodule